// File: doc/BRIEF.md
# Converter Result FIFO with Trigger

This block is a sixteen-slot circular store placed between a multichannel data converter and a host processor. Each finished conversion arrives on a strobe together with the tag of its channel. The block stores the sample and its tag without any help from the host. The host drains the store one item per read. Because the channel sequencer upstream produces results in a fixed repeating order, and the host always removes whole groups, the first item of every group belongs to the first channel of that order.

A small control field selects a group size from 1 to 16. A trigger pointer marks the slot where the current group ends. When a write lands on that slot, the data-available output goes high, and the host can use it as an interrupt. The output stays high until the host has read a whole group and no further complete group is waiting. The read pointer names the slot the next read returns. The write pointer names the slot that holds the newest sample. A synchronous clear input empties the store and loads a new group size. Sticky flags record writes that were lost because the store was full, and reads that were made while it was empty.

Top module: `conv_result_fifo`

## Requirements
- R1: While reset is held, and after it is released, `data_av`, `ovf_flag` and `unf_flag` are 0 and `host_data`/`host_chan` are 0. The group size after reset is 1, which is code 0.
- R2: Items are returned in the order they were accepted, each with its own channel tag. Storage wraps from slot 15 back to slot 0 with no gap.
- R3: A write that arrives while 16 unread items are held is dropped, even if a read happens in the same cycle. `ovf_flag` is set from the next cycle and stays set until `fifo_clr`.
- R4: A read made while the store is empty leaves `host_data`/`host_chan` unchanged and leaves the pointers unchanged, so later items still come back in order. `unf_flag` is set from the next cycle and stays set until `fifo_clr`.
- R5: A read accepted at a clock edge presents its item on `host_data`/`host_chan` directly after that edge. The item is held until the next accepted read.
- R6: The group size is L = `trig_sel` + 1, so code 0 means 1 and code 15 means 16. `data_av` rises directly after the edge at which the write completing a group of L accepted samples is stored.
- R7: `data_av` falls directly after the edge at which the host's read completes a group of L items, unless another complete group is still waiting, in which case it stays high.
- R8: A new `trig_sel` value has no effect until `fifo_clr` is sampled high. `fifo_clr` empties the store, returns all pointers to slot 0, clears `data_av`, `ovf_flag` and `unf_flag`, and loads `trig_sel`. It takes priority over any read or write in the same cycle.
- R9: The extreme group sizes of 1 and 16 work. With L=16, `data_av` rises only with the sixteenth sample.
- R10: A read and a write in the same cycle on a non-empty, non-full store are both performed, and the fill level does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fifo_clr | input | 1 | Synchronous clear of the store; loads the group size |
| trig_sel | input | 4 | Group size code, L = code + 1 |
| cv_valid | input | 1 | Conversion result strobe |
| cv_data | input | 10 | Conversion result |
| cv_chan | input | 2 | Channel tag of the result |
| host_rd | input | 1 | Host read request |
| host_data | output | 10 | Sample returned by the last accepted read |
| host_chan | output | 2 | Channel tag returned by the last accepted read |
| data_av | output | 1 | A complete group is waiting |
| ovf_flag | output | 1 | Sticky: a write was dropped while full |
| unf_flag | output | 1 | Sticky: a read was made while empty |

## Verification
A wrong read pointer or a wrong fill count shows up on the very next read as a sample or tag that does not match the scoreboard. A slip of one slot also shifts the channel order seen by the host. If the trigger pointer or the group counters are corrupted, `data_av` changes one cycle early or late relative to the write or read that should move it, and the bench compares that output every cycle. Fill-count errors at the limits show up on the sticky flags one cycle after the offending request.

// File: rtl/conv_fifo_pkg.sv
package conv_fifo_pkg;
  localparam int SLOTS_DEF  = 16;
  localparam int SMP_W_DEF  = 10;
  localparam int TAG_W_DEF  = 2;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cfifo_store.sv
module cfifo_store #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int W     = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_word,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_word
);
  logic [W-1:0]     slot_q [DEPTH];
  logic [DEPTH-1:0] slot_we;
  logic [W-1:0]     rd_word_q, rd_word_d;

  // one-hot write decode, one enable per slot
  for (genvar i = 0; i < DEPTH; i++) begin : g_dec
    assign slot_we[i] = wr_en && (wr_addr == AW'(i));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (slot_we[i]) slot_q[i] <= wr_word;
    end
  end

  always_comb begin
    rd_word_d = rd_word_q;
    if (rd_en) rd_word_d = slot_q[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_word_q <= '0;
    else if (rd_en) rd_word_q <= rd_word_d;
  end

  assign rd_word = rd_word_q;

  assert_onehot_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_we));
  assert_hold_no_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_word));
endmodule

// File: rtl/cfifo_ptrs.sv
module cfifo_ptrs #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_req,
  input  logic          rd_req,
  output logic          wr_fire,
  output logic          rd_fire,
  output logic [AW-1:0] wr_slot,
  output logic [AW-1:0] rd_slot,
  output logic          ovf,
  output logic          unf
);
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [AW-1:0] wr_ptr_q, wr_ptr_d;   // slot of the newest sample
  logic [CW-1:0] fill_q, fill_d;
  logic          ovf_q, ovf_d, unf_q, unf_d;
  logic          full, empty;

  assign full    = (fill_q == CW'(DEPTH));
  assign empty   = (fill_q == '0);
  assign wr_fire = wr_req && !clr && !full;
  assign rd_fire = rd_req && !clr && !empty;
  assign wr_slot = rd_ptr_q + fill_q[AW-1:0];
  assign rd_slot = rd_ptr_q;

  always_comb begin
    rd_ptr_d = rd_ptr_q;
    wr_ptr_d = wr_ptr_q;
    fill_d   = fill_q;
    ovf_d    = ovf_q;
    unf_d    = unf_q;
    if (clr) begin
      rd_ptr_d = '0;
      wr_ptr_d = '0;
      fill_d   = '0;
      ovf_d    = 1'b0;
      unf_d    = 1'b0;
    end else begin
      if (wr_fire) wr_ptr_d = wr_slot;
      if (rd_fire) rd_ptr_d = rd_ptr_q + AW'(1);
      fill_d = fill_q + CW'(wr_fire) - CW'(rd_fire);
      if (wr_req && full)  ovf_d = 1'b1;
      if (rd_req && empty) unf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      fill_q   <= '0;
      ovf_q    <= 1'b0;
      unf_q    <= 1'b0;
    end else begin
      rd_ptr_q <= rd_ptr_d;
      wr_ptr_q <= wr_ptr_d;
      fill_q   <= fill_d;
      ovf_q    <= ovf_d;
      unf_q    <= unf_d;
    end
  end

  assign ovf = ovf_q;
  assign unf = unf_q;

  assert_fill_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= CW'(DEPTH));
  assert_wr_ptr_newest_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !empty |-> (wr_ptr_q == rd_ptr_q + fill_q[AW-1:0] - AW'(1)));
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_req && !rd_req && !clr) |=> (full && ovf));
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_req && !wr_req && !clr) |=> (empty && unf && $stable(rd_ptr_q)));
  assert_flags_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr) |=> ovf);
  assert_flags_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (unf && !clr) |=> unf);
  assert_rw_same_fill_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && rd_fire) |=> $stable(fill_q));
endmodule

// File: rtl/cfifo_trig.sv
module cfifo_trig #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [AW-1:0] trig_code,
  input  logic          wr_fire,
  input  logic [AW-1:0] wr_slot,
  input  logic          rd_fire,
  output logic          data_av
);
  logic [AW-1:0] lvl_q, lvl_d;        // applied group size minus one
  logic [AW-1:0] trig_ptr_q, trig_ptr_d;
  logic [AW-1:0] rd_grp_q, rd_grp_d;
  logic [CW-1:0] groups_q, groups_d;
  logic          wgrp_done, rgrp_done;

  assign wgrp_done = wr_fire && (wr_slot == trig_ptr_q);
  assign rgrp_done = rd_fire && (rd_grp_q == lvl_q);

  always_comb begin
    lvl_d      = lvl_q;
    trig_ptr_d = trig_ptr_q;
    rd_grp_d   = rd_grp_q;
    groups_d   = groups_q;
    if (clr) begin
      lvl_d      = trig_code;
      trig_ptr_d = trig_code;          // pointers restart at slot 0
      rd_grp_d   = '0;
      groups_d   = '0;
    end else begin
      if (wgrp_done) trig_ptr_d = trig_ptr_q + lvl_q + AW'(1);
      if (rd_fire)   rd_grp_d   = rgrp_done ? '0 : rd_grp_q + AW'(1);
      groups_d = groups_q + CW'(wgrp_done) - CW'(rgrp_done);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q      <= '0;
      trig_ptr_q <= '0;
      rd_grp_q   <= '0;
      groups_q   <= '0;
    end else begin
      lvl_q      <= lvl_d;
      trig_ptr_q <= trig_ptr_d;
      rd_grp_q   <= rd_grp_d;
      groups_q   <= groups_d;
    end
  end

  assign data_av = (groups_q != '0);

  assert_av_rise_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_av) |-> $past(wr_fire));
  assert_av_fall_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_av) |-> $past(rd_fire || clr));
  assert_group_exists_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rgrp_done |-> (groups_q != '0));
  assert_level_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> $stable(lvl_q));
  assert_groups_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    groups_q <= CW'(DEPTH));
endmodule

// File: rtl/conv_result_fifo.sv
module conv_result_fifo
  import conv_fifo_pkg::*;
#(
  parameter int DEPTH  = SLOTS_DEF,
  parameter int DATA_W = SMP_W_DEF,
  parameter int CHAN_W = TAG_W_DEF
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      fifo_clr,
  input  logic [idx_w(DEPTH)-1:0]   trig_sel,
  input  logic                      cv_valid,
  input  logic [DATA_W-1:0]         cv_data,
  input  logic [CHAN_W-1:0]         cv_chan,
  input  logic                      host_rd,
  output logic [DATA_W-1:0]         host_data,
  output logic [CHAN_W-1:0]         host_chan,
  output logic                      data_av,
  output logic                      ovf_flag,
  output logic                      unf_flag
);
  localparam int AW = idx_w(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int W  = DATA_W + CHAN_W;

  logic          rst_meta_q, rst_sync_q;
  logic          wr_fire, rd_fire;
  logic [AW-1:0] wr_slot, rd_slot;
  logic [W-1:0]  rd_word;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  cfifo_ptrs #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ptrs (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .clr     (fifo_clr),
    .wr_req  (cv_valid),
    .rd_req  (host_rd),
    .wr_fire (wr_fire),
    .rd_fire (rd_fire),
    .wr_slot (wr_slot),
    .rd_slot (rd_slot),
    .ovf     (ovf_flag),
    .unf     (unf_flag)
  );

  cfifo_store #(.DEPTH(DEPTH), .AW(AW), .W(W)) u_store (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .wr_en   (wr_fire),
    .wr_addr (wr_slot),
    .wr_word ({cv_chan, cv_data}),
    .rd_en   (rd_fire),
    .rd_addr (rd_slot),
    .rd_word (rd_word)
  );

  cfifo_trig #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_trig (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .clr       (fifo_clr),
    .trig_code (trig_sel),
    .wr_fire   (wr_fire),
    .wr_slot   (wr_slot),
    .rd_fire   (rd_fire),
    .data_av   (data_av)
  );

  assign host_chan = rd_word[W-1:DATA_W];
  assign host_data = rd_word[DATA_W-1:0];

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_sync_q |-> (!data_av && !ovf_flag && !unf_flag));
  assert_clr_clears_R8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    fifo_clr |=> (!data_av && !ovf_flag && !unf_flag));
endmodule

// File: tb/conv_result_fifo_test.sv
module conv_result_fifo_test;
  localparam int D = 16, DW = 10, CH = 2, AW = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, fifo_clr, cv_valid, host_rd;
  logic [AW-1:0] trig_sel;
  logic [DW-1:0] cv_data;
  logic [CH-1:0] cv_chan;
  logic [DW-1:0] host_data;
  logic [CH-1:0] host_chan;
  logic          data_av, ovf_flag, unf_flag;

  conv_result_fifo uut (
    .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .trig_sel(trig_sel),
    .cv_valid(cv_valid), .cv_data(cv_data), .cv_chan(cv_chan),
    .host_rd(host_rd), .host_data(host_data), .host_chan(host_chan),
    .data_av(data_av), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  typedef struct packed { logic [CH-1:0] c; logic [DW-1:0] d; } item_t;

  int    checks = 0, fails = 0;
  item_t sb[$];
  item_t last_rd = '0;
  int    m_cnt = 0, m_lvl = 1, m_wg = 0, m_rg = 0, m_groups = 0;
  bit    exp_ovf = 0, exp_unf = 0, rd_pend = 0, empty_rd_pend = 0, armed = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // driver: applies one cycle and pushes expected items
  task automatic cyc(input bit w, input bit r, input int c, input int d);
    bit wr_ok, rd_ok;
    cv_valid = w; host_rd = r;
    cv_chan = CH'(c); cv_data = DW'(d);
    @(posedge clk);
    wr_ok = w && (m_cnt < D);
    rd_ok = r && (m_cnt > 0);
    if (rd_ok) rd_pend = 1;
    if (r && !rd_ok) begin empty_rd_pend = 1; exp_unf = 1; end
    if (w && !wr_ok) exp_ovf = 1;
    if (wr_ok) begin
      sb.push_back({CH'(c), DW'(d)});
      m_wg++;
      if (m_wg == m_lvl) begin m_wg = 0; m_groups++; end
    end
    if (rd_ok) begin
      m_rg++;
      if (m_rg == m_lvl) begin m_rg = 0; m_groups--; end
    end
    m_cnt += int'(wr_ok) - int'(rd_ok);
    @(negedge clk);
    cv_valid = 0; host_rd = 0;
  endtask

  task automatic do_clr(input int code);
    fifo_clr = 1; trig_sel = AW'(code);
    @(posedge clk);
    sb.delete();
    m_cnt = 0; m_wg = 0; m_rg = 0; m_groups = 0; m_lvl = code + 1;
    exp_ovf = 0; exp_unf = 0;
    @(negedge clk);
    fifo_clr = 0;
  endtask

  // monitor: pops the scoreboard and checks outputs after each edge
  always @(negedge clk) begin
    if (armed) begin
      if (rd_pend) begin
        item_t exp_it;
        exp_it = sb.pop_front();
        chk({host_chan, host_data} == exp_it, "R2/R5 read item",
            int'({host_chan, host_data}), int'(exp_it));
        last_rd = exp_it;
        rd_pend = 0;
      end
      if (empty_rd_pend) begin
        chk({host_chan, host_data} == last_rd, "R4 empty read holds data",
            int'({host_chan, host_data}), int'(last_rd));
        empty_rd_pend = 0;
      end
      chk(data_av == (m_groups > 0), "R6/R7 data_av", int'(data_av), int'(m_groups > 0));
      chk(ovf_flag == exp_ovf, "R3 ovf_flag", int'(ovf_flag), int'(exp_ovf));
      chk(unf_flag == exp_unf, "R4 unf_flag", int'(unf_flag), int'(exp_unf));
    end
  end

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; fifo_clr = 0; cv_valid = 0; host_rd = 0;
    trig_sel = '0; cv_data = '0; cv_chan = '0;
    repeat (3) @(negedge clk);
    // R1: reset state while held
    chk(!data_av && !ovf_flag && !unf_flag, "R1 flags in reset",
        int'({data_av, ovf_flag, unf_flag}), 0);
    chk(host_data == '0 && host_chan == '0, "R1 read data in reset", int'(host_data), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!data_av && !ovf_flag && !unf_flag, "R1 flags after release",
        int'({data_av, ovf_flag, unf_flag}), 0);
    armed = 1;

    // R6/R7: group of four, code 3
    do_clr(3);
    for (int i = 0; i < 3; i++) cyc(1, 0, i, 100 + i);
    chk(!data_av, "R6 no trigger before group", int'(data_av), 0);
    cyc(1, 0, 3, 103);
    chk(data_av, "R6 trigger on fourth write", int'(data_av), 1);
    for (int i = 0; i < 3; i++) begin
      cyc(0, 1, 0, 0);
      chk(data_av, "R7 held during group read", int'(data_av), 1);
    end
    cyc(0, 1, 0, 0);
    chk(!data_av, "R7 drop after group read", int'(data_av), 0);
    chk(host_chan == 2'd3, "R2 last channel of group", int'(host_chan), 3);

    // R7: two groups waiting
    for (int i = 0; i < 8; i++) cyc(1, 0, i % 4, 200 + i);
    for (int i = 0; i < 4; i++) cyc(0, 1, 0, 0);
    chk(data_av, "R7 second group keeps data_av", int'(data_av), 1);
    chk(host_chan == 2'd3, "R2 first group ends on channel 3", int'(host_chan), 3);
    for (int i = 0; i < 4; i++) cyc(0, 1, 0, 0);
    chk(!data_av, "R7 all groups read", int'(data_av), 0);

    // R8: new code ignored until clear
    trig_sel = 4'd0;
    cyc(1, 0, 0, 300);
    chk(!data_av, "R8 code change ignored without clear", int'(data_av), 0);
    for (int i = 1; i < 4; i++) cyc(1, 0, i, 300 + i);
    chk(data_av, "R8 old group size still active", int'(data_av), 1);
    do_clr(0);
    chk(!data_av, "R8 clear drops data_av", int'(data_av), 0);
    cyc(1, 0, 0, 310);
    chk(data_av, "R9 group size one", int'(data_av), 1);
    cyc(0, 1, 0, 0);
    chk(!data_av, "R9 group size one drained", int'(data_av), 0);

    // R9/R3: group of sixteen and overflow
    do_clr(15);
    for (int i = 0; i < 15; i++) cyc(1, 0, i % 4, 400 + i);
    chk(!data_av, "R9 fifteen of sixteen", int'(data_av), 0);
    cyc(1, 0, 3, 415);
    chk(data_av, "R9 sixteenth write triggers", int'(data_av), 1);
    cyc(1, 0, 0, 999);
    chk(ovf_flag, "R3 write while full sets flag", int'(ovf_flag), 1);
    cyc(1, 1, 1, 998);
    chk(ovf_flag, "R3 flag sticky; write with read dropped", int'(ovf_flag), 1);
    for (int i = 0; i < 15; i++) cyc(0, 1, 0, 0);
    chk(!data_av, "R7 sixteen read", int'(data_av), 0);
    chk(host_data == DW'(415), "R3 dropped write not stored", int'(host_data), 415);

    // R4: underflow
    cyc(0, 1, 0, 0);
    chk(unf_flag, "R4 empty read sets flag", int'(unf_flag), 1);
    cyc(1, 0, 2, 500);
    cyc(0, 1, 0, 0);
    chk(host_data == DW'(500) && host_chan == 2'd2, "R4 pointers unchanged",
        int'(host_data), 500);

    // R8: clear drops sticky flags
    do_clr(1);
    chk(!ovf_flag && !unf_flag, "R8 clear drops flags",
        int'({ovf_flag, unf_flag}), 0);

    // R10/R2: simultaneous traffic across wrap
    cyc(1, 0, 0, 600);
    for (int i = 1; i < 41; i++) cyc(1, 1, i % 4, 600 + i);
    chk(!ovf_flag && !unf_flag, "R10 no flags under streaming",
        int'({ovf_flag, unf_flag}), 0);
    cyc(0, 1, 0, 0);
    chk(host_data == DW'(640), "R10 final item", int'(host_data), 640);

    @(negedge clk);
    armed = 0;
    summary();
    $finish;
  end
endmodule